// File: doc/BRIEF.md
# Video RAM with Row Transfer and Serial Readout

This block is a synthesizable behavioural model of a dual-port video memory. One side is an ordinary random-access byte array, reached through a multiplexed address bus and a pair of active-low row and column strobes. The other side is a 512-entry line buffer of 8-bit values, which feeds a serial output. A transfer cycle copies a whole row of the array into the line buffer in one operation. Serial clocks then step through the buffer, starting from a chosen column.

A cycle generator samples the strobes on the system clock and turns their edges into single-cycle events: transfer, random read or random write. The combined transfer/output-enable control is looked at only at the row-strobe edge. If it is low there, the cycle is a transfer, and the column given later in the cycle becomes the first serial tap. Otherwise the cycle is a random access.

All pins are sampled by `clk`, and a strobe edge is seen at the first clock edge that finds the new level.

Top module: `vram_xfer_top`

## Requirements
- R1: After reset, `dout` and `sout` are 0 and the serial pointer is 0.
- R2: A cycle is a transfer only if `dtoe_n` is low at the clock edge that first sees `ras_n` low. A later change of `dtoe_n` within the same cycle does not change the cycle type.
- R3: In a transfer cycle, the row latched from `addr` at the row-strobe edge is copied in full (all 512 entries) into the line buffer, at the edge that first sees `cas_n` low.
- R4: The column on `addr` at that column-strobe edge becomes the serial tap. The first serial clock after the transfer outputs the buffer entry at that column.
- R5: Each rising edge of `sclk` presents the next buffer entry on `sout` at the clock edge that first sees `sclk` high. `sout` holds its value at all other times.
- R6: The serial pointer wraps from column 511 back to column 0.
- R7: In a random cycle (`dtoe_n` high at the row-strobe edge), the column-strobe edge does one of two things. If `we_n` is low, it writes `din` to the cell at the latched row and column. If `we_n` is high, it loads that cell into `dout` at the same clock edge.
- R8: Random reads and writes change neither the line buffer contents nor the serial pointer. The buffer keeps the copy made at the transfer, even when the array cell behind it is later rewritten.
- R9: A column-strobe edge while `ras_n` is high has no effect on the array or on `dout`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| dtoe_n | input | 1 | Transfer select, sampled at the row-strobe edge, active low |
| we_n | input | 1 | Write enable for random cycles, active low |
| addr | input | 9 | Multiplexed address: row at the row strobe, column at the column strobe |
| din | input | 8 | Random write data |
| dout | output | 8 | Random read data, registered |
| sclk | input | 1 | Serial clock, rising edge advances the readout |
| sout | output | 8 | Serial output from the line buffer |

## Verification
The assertions assume that each strobe is held for at least one clock on each level. They also assume that a serial clock edge and the column-strobe edge of a transfer never fall on the same sampling edge; when they do, the transfer wins. The stimulus meets both assumptions: every pin changes only on the falling clock edge, each strobe phase lasts at least one full clock, and `sclk` stays low throughout every transfer cycle. Every array row is written before it is transferred, so no check ever depends on contents that were never written.

// File: rtl/vram_pkg.sv
package vram_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE   = 2'd0,
    CYC_RANDOM = 2'd1,
    CYC_XFER   = 2'd2
  } cyc_kind_t;

  // linear cell number of (row, col) in an array of rows of 'cols' cells
  function automatic int unsigned flat_cell(input int unsigned row,
                                            input int unsigned col,
                                            input int unsigned cols);
    return row * cols + col;
  endfunction

  // serial tap following p in a buffer of 'len' entries, wrapping to 0
  function automatic int unsigned tap_after(input int unsigned p,
                                            input int unsigned len);
    return (p + 1 >= len) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/vram_strobe_seq.sv
module vram_strobe_seq
  import vram_pkg::*;
#(
  parameter int ROW_W  = 2,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              dtoe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [ROW_W-1:0]  row_sel,
  output logic [COL_W-1:0]  col_sel,
  output logic              xfer_evt,
  output logic              rd_evt,
  output logic              wr_evt
);

  logic      ras_q, cas_q;
  cyc_kind_t cyc_q;
  logic      ras_fall, cas_fall, in_cycle;

  assign ras_fall = ras_q & ~ras_n;
  assign cas_fall = cas_q & ~cas_n;
  assign in_cycle = (cyc_q != CYC_IDLE) & ~ras_n;

  assign col_sel  = addr[COL_W-1:0];
  assign xfer_evt = cas_fall & in_cycle & (cyc_q == CYC_XFER);
  assign rd_evt   = cas_fall & in_cycle & (cyc_q == CYC_RANDOM) & we_n;
  assign wr_evt   = cas_fall & in_cycle & (cyc_q == CYC_RANDOM) & ~we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
      cyc_q   <= CYC_IDLE;
      row_sel <= '0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      if (ras_n) begin
        cyc_q <= CYC_IDLE;
      end else if (ras_fall) begin
        cyc_q   <= dtoe_n ? CYC_RANDOM : CYC_XFER;
        row_sel <= addr[ROW_W-1:0];
      end
    end
  end

  // R2
  seq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xfer_evt, rd_evt, wr_evt}));

  // R9
  no_orphan_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ras_n |-> !(xfer_evt || rd_evt || wr_evt));

  // R2
  xfer_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !dtoe_n) |=> (!ras_n -> !(rd_evt || wr_evt)));

endmodule

// File: rtl/vram_array.sv
module vram_array
  import vram_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 512,
  parameter int DATA_W = 8,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ROW_W-1:0]              row_sel,
  input  logic [COL_W-1:0]              col_sel,
  input  logic                          rd_evt,
  input  logic                          wr_evt,
  input  logic [DATA_W-1:0]             din,
  output logic [DATA_W-1:0]             dout,
  output logic [COLS-1:0][DATA_W-1:0]   row_data
);

  localparam int CELLS = ROWS * COLS;
  localparam int IDX_W = $clog2(CELLS);

  logic [DATA_W-1:0] mem [CELLS];
  logic [IDX_W-1:0]  cell_idx;

  assign cell_idx = IDX_W'(flat_cell(int'(row_sel), int'(col_sel), COLS));

  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      row_data[c] = mem[IDX_W'(flat_cell(int'(row_sel), c, COLS))];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_evt) begin
      mem[cell_idx] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (rd_evt) begin
      dout <= mem[cell_idx];
    end
  end

  // R7
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> mem[$past(cell_idx)] == $past(din));

  // R9
  dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> $stable(dout));

endmodule

// File: rtl/vram_line_buffer.sv
module vram_line_buffer
  import vram_pkg::*;
#(
  parameter int COLS   = 512,
  parameter int DATA_W = 8,
  parameter int COL_W  = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        xfer_evt,
  input  logic [COL_W-1:0]            col_sel,
  input  logic [COLS-1:0][DATA_W-1:0] row_data,
  input  logic                        sclk,
  output logic [DATA_W-1:0]           sout,
  output logic [COL_W-1:0]            tap_ptr,
  output logic                        shift_evt
);

  logic [DATA_W-1:0] line [COLS];
  logic              sclk_q;
  logic [DATA_W-1:0] head;

  assign shift_evt = sclk & ~sclk_q & ~xfer_evt;
  assign head      = line[tap_ptr];

  always_ff @(posedge clk) begin
    if (xfer_evt) begin
      for (int c = 0; c < COLS; c++) begin
        line[c] <= row_data[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      tap_ptr <= '0;
      sout    <= '0;
    end else begin
      sclk_q <= sclk;
      if (xfer_evt) begin
        tap_ptr <= col_sel;
      end else if (shift_evt) begin
        sout    <= head;
        tap_ptr <= COL_W'(tap_after(int'(tap_ptr), COLS));
      end
    end
  end

  // R5
  sout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_evt |=> $stable(sout));

  // R5
  shift_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> sout == $past(head));

  // R6
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_evt && tap_ptr == COL_W'(COLS - 1)) |=> tap_ptr == '0);

  // R4
  tap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_evt |=> tap_ptr == $past(col_sel));

endmodule

// File: rtl/vram_xfer_top.sv
module vram_xfer_top
  import vram_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 512,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              dtoe_n,
  input  logic              we_n,
  input  logic [8:0]        addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  input  logic              sclk,
  output logic [DATA_W-1:0] sout
);

  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int COL_W  = $clog2(COLS);
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic [ROW_W-1:0]              row_sel;
  logic [COL_W-1:0]              col_sel;
  logic                          xfer_evt, rd_evt, wr_evt, shift_evt;
  logic [COLS-1:0][DATA_W-1:0]   row_data;
  logic [COL_W-1:0]              tap_ptr;
  logic [ADDR_W-1:0]             addr_w;

  assign addr_w = ADDR_W'(addr);

  vram_strobe_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
    .dtoe_n(dtoe_n), .we_n(we_n), .addr(addr_w),
    .row_sel(row_sel), .col_sel(col_sel),
    .xfer_evt(xfer_evt), .rd_evt(rd_evt), .wr_evt(wr_evt)
  );

  vram_array #(.ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W),
               .ROW_W(ROW_W), .COL_W(COL_W)) u_array (
    .clk(clk), .rst_n(rst_n), .row_sel(row_sel), .col_sel(col_sel),
    .rd_evt(rd_evt), .wr_evt(wr_evt), .din(din), .dout(dout),
    .row_data(row_data)
  );

  vram_line_buffer #(.COLS(COLS), .DATA_W(DATA_W), .COL_W(COL_W)) u_line (
    .clk(clk), .rst_n(rst_n), .xfer_evt(xfer_evt), .col_sel(col_sel),
    .row_data(row_data), .sclk(sclk), .sout(sout),
    .tap_ptr(tap_ptr), .shift_evt(shift_evt)
  );

  // R8
  random_keeps_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_evt || wr_evt) && !shift_evt) |=> $stable(tap_ptr));

  // R1
  reset_tap_chk: assert property (@(posedge clk)
    !rst_n |=> (tap_ptr == '0 && sout == '0 && dout == '0));

endmodule

// File: tb/vram_xfer_top_test.sv
module vram_xfer_top_test;

  localparam int ROWS = 4;
  localparam int COLS = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ras_n = 1'b1, cas_n = 1'b1, dtoe_n = 1'b1, we_n = 1'b1, sclk = 1'b0;
  logic [8:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout, sout;

  int compared = 0;
  int mismatched = 0;

  logic [7:0] mem_m [ROWS*COLS];
  logic [7:0] buf_m [COLS];
  int         ptr_m = 0;

  always #2.5 clk = ~clk;

  vram_xfer_top uut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .dtoe_n(dtoe_n),
    .we_n(we_n), .addr(addr), .din(din), .dout(dout), .sclk(sclk), .sout(sout)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int r, input int c);
    return 8'((r * 61 + c * 3 + (c >> 4) + 7) & 255);
  endfunction

  task automatic wr_cell(input int r, input int c, input logic [7:0] d);
    ras_n = 1'b0; dtoe_n = 1'b1; addr = 9'(r); tick();
    cas_n = 1'b0; we_n = 1'b0; addr = 9'(c); din = d; tick();
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; tick();
    mem_m[r*COLS+c] = d;
  endtask

  task automatic rd_cell(input string req, input int r, input int c);
    ras_n = 1'b0; dtoe_n = 1'b1; addr = 9'(r); tick();
    cas_n = 1'b0; we_n = 1'b1; addr = 9'(c); tick();
    check(req, dout, mem_m[r*COLS+c]);
    ras_n = 1'b1; cas_n = 1'b1; tick();
  endtask

  task automatic xfer(input int r, input int c);
    ras_n = 1'b0; dtoe_n = 1'b0; addr = 9'(r); tick();
    dtoe_n = 1'b1; cas_n = 1'b0; addr = 9'(c); tick();
    ras_n = 1'b1; cas_n = 1'b1; tick();
    for (int i = 0; i < COLS; i++) buf_m[i] = mem_m[r*COLS+i];
    ptr_m = c;
  endtask

  task automatic shift_chk(input string req);
    sclk = 1'b1; tick();
    check(req, sout, buf_m[ptr_m]);
    ptr_m = (ptr_m + 1) % COLS;
    sclk = 1'b0; tick();
  endtask

  task automatic t_reset();
    check("R1 dout", dout, 8'h00);
    check("R1 sout", sout, 8'h00);
  endtask

  task automatic t_fill();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) wr_cell(r, c, pat(r, c));
    rd_cell("R7 read", 0, 0);
    rd_cell("R7 read", 2, 300);
    rd_cell("R7 read", 3, 511);
    wr_cell(1, 77, 8'h5A);
    rd_cell("R7 rewrite", 1, 77);
  endtask

  task automatic t_tap();
    xfer(2, 10);
    for (int i = 0; i < 4; i++) shift_chk("R4 R3 tap shift");
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R5 hold", sout, buf_m[(ptr_m + COLS - 1) % COLS]);
    end
  endtask

  task automatic t_wrap();
    xfer(1, 509);
    for (int i = 0; i < 5; i++) shift_chk("R6 wrap");
  endtask

  task automatic t_full_row();
    xfer(3, 0);
    for (int i = 0; i < COLS + 2; i++) shift_chk("R3 full row");
  endtask

  task automatic t_late_dtoe();
    xfer(0, 100);
    shift_chk("R2 pre");
    ras_n = 1'b0; dtoe_n = 1'b1; addr = 9'd2; tick();
    dtoe_n = 1'b0; cas_n = 1'b0; we_n = 1'b1; addr = 9'd40; tick();
    check("R2 late dtoe read", dout, mem_m[2*COLS+40]);
    ras_n = 1'b1; cas_n = 1'b1; dtoe_n = 1'b1; tick();
    shift_chk("R2 buffer kept");
    shift_chk("R2 buffer kept");
  endtask

  task automatic t_no_disturb();
    xfer(2, 200);
    shift_chk("R8 pre");
    wr_cell(2, 201, 8'hC3);
    wr_cell(2, 202, 8'h3C);
    rd_cell("R8 array updated", 2, 201);
    shift_chk("R8 buffer copy kept");
    shift_chk("R8 buffer copy kept");
  endtask

  task automatic t_orphan_cas();
    logic [7:0] before_dout;
    rd_cell("R9 setup", 0, 5);
    before_dout = dout;
    cas_n = 1'b0; we_n = 1'b0; addr = 9'd5; din = 8'hEE; tick();
    check("R9 dout", dout, before_dout);
    cas_n = 1'b1; we_n = 1'b1; tick();
    cas_n = 1'b0; addr = 9'd9; tick();
    check("R9 no read", dout, before_dout);
    cas_n = 1'b1; tick();
    rd_cell("R9 cell unchanged", 0, 5);
  endtask

  initial begin
    for (int i = 0; i < COLS; i++) buf_m[i] = 8'h00;
    repeat (3) tick();
    t_reset();
    shift_chk("R1 pointer zero");
    rst_n = 1'b1;
    tick();
    t_fill();
    t_tap();
    t_wrap();
    t_full_row();
    t_late_dtoe();
    t_no_disturb();
    t_orphan_cas();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule